// File: doc/BRIEF.md
# Carry-select adder with increment converter

This block is a purely combinational two-operand adder. It takes two 16-bit operands and a carry input, and it returns a 16-bit sum and one carry output. The operand width is cut into 4-bit slices. The lowest slice is a plain ripple chain that the external carry drives directly.

Each higher slice forms only one ripple result, which assumes a carry of zero into the slice. The result for an incoming carry of one comes from a small add-one network applied to that zero-carry result, so the slice needs no second ripple chain. The carry leaving the slice below then steers a multiplexer between the two results.

The block has no clock and no reset. A user places it between registers, and the full-width sum is valid once the carry-select path has settled.

Top module: `csa_inc_adder`

## Requirements
- R1: For every input combination, the 17-bit value {carry_out, sum_out} equals op_a + op_b + carry_in, computed at 17 bits.
- R2: The lowest slice is driven by the external carry. sum_out[3:0] equals the low four bits of op_a[3:0] + op_b[3:0] + carry_in.
- R3: Each upper slice k (k = 1..3, bits 4k+3..4k) produces op_a slice + op_b slice + the carry out of bits below 4k, modulo 16. With an incoming carry of 1, this is the zero-carry slice sum plus one, wrapping from 15 to 0.
- R4: The carry out of an upper slice is its zero-carry carry when the incoming carry is 0. When the incoming carry is 1, the carry out is the zero-carry carry OR the condition that all four zero-carry sum bits are 1.
- R5: All-ones operands with carry_in = 1 give sum_out = 16'hFFFF and carry_out = 1.
- R6: Zero operands give sum_out = 0 and carry_out = 0 with carry_in = 0. They give sum_out = 1 and carry_out = 0 with carry_in = 1.
- R7: A carry started in bit 0 travels across every slice boundary. op_a = 16'hFFFF, op_b = 0, carry_in = 1 gives sum_out = 0 and carry_out = 1. op_a = 16'h0FFF, op_b = 0, carry_in = 1 gives sum_out = 16'h1000 and carry_out = 0.
- R8: For low-slice operands 4'b1011 and 4'b1101 with carry_in = 0, the low slice yields 4'b1000 and a carry of 1 into the next slice. With op_a = 16'h000B and op_b = 16'h000D, sum_out = 16'h0018 and carry_out = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Sum, modulo 2^16 |
| carry_out | output | 1 | Carry out of the top slice |

## Verification
The hardest case to reach is an upper slice whose zero-carry sum is all ones while a carry of one arrives from below. Only in that case does the add-one network wrap the slice to zero and create the slice's carry out, so that this carry then feeds the next multiplexer. Random operands hit it for a given slice only about once in thirty-two vectors. The stimulus therefore also walks directed operands whose slices sum to 4'hF, and it injects the carry from below through carry_in or a lower slice that overflows. This drives the wrap through one, two and all three upper slices.

// File: rtl/csa_pkg.sv
package csa_pkg;
    localparam int unsigned CSA_DATA_W = 16;
    localparam int unsigned CSA_GRP_W  = 4;
endpackage

// File: rtl/csa_ripple.sv
module csa_ripple #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] c;
    assign c[0] = ci;
    for (genvar i = 0; i < W; i++) begin : g_fa
        logic p;
        assign p        = a[i] ^ b[i];
        assign s[i]     = p ^ c[i];
        assign c[i+1]   = (a[i] & b[i]) | (c[i] & p);
    end
    assign co = c[W];
endmodule

// File: rtl/csa_inc_conv.sv
module csa_inc_conv #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] bin,
    output logic [W-1:0] xs1,
    output logic         all_one
);
    // prefix AND of lower bits: bit i toggles when every lower bit is 1
    logic [W:0] pre;
    assign pre[0] = 1'b1;
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign xs1[i]   = bin[i] ^ pre[i];
        assign pre[i+1] = pre[i] & bin[i];
    end
    assign all_one = pre[W];
endmodule

// File: rtl/csa_group.sv
module csa_group #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sel_c,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W-1:0] zs;
    logic         zc;
    logic [W-1:0] os;
    logic         ones;

    csa_ripple #(.W(W)) u_rca (
        .a (a),
        .b (b),
        .ci(1'b0),
        .s (zs),
        .co(zc)
    );

    csa_inc_conv #(.W(W)) u_conv (
        .bin    (zs),
        .xs1    (os),
        .all_one(ones)
    );

    always_comb begin
        if (sel_c) begin
            s  = os;
            co = zc | ones;
        end else begin
            s  = zs;
            co = zc;
        end
    end
endmodule

// File: rtl/csa_inc_adder.sv
module csa_inc_adder
    import csa_pkg::*;
#(
    parameter int unsigned DATA_W = CSA_DATA_W,
    parameter int unsigned GRP_W  = CSA_GRP_W
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              carry_in,
    output logic [DATA_W-1:0] sum_out,
    output logic              carry_out
);
    localparam int unsigned NGRP = DATA_W / GRP_W;

    logic [NGRP:0] gc;
    assign gc[0] = carry_in;

    for (genvar g = 0; g < NGRP; g++) begin : g_slice
        if (g == 0) begin : g_base
            csa_ripple #(.W(GRP_W)) u_base (
                .a (op_a[GRP_W-1:0]),
                .b (op_b[GRP_W-1:0]),
                .ci(gc[0]),
                .s (sum_out[GRP_W-1:0]),
                .co(gc[1])
            );
        end else begin : g_sel
            csa_group #(.W(GRP_W)) u_grp (
                .a    (op_a[g*GRP_W +: GRP_W]),
                .b    (op_b[g*GRP_W +: GRP_W]),
                .sel_c(gc[g]),
                .s    (sum_out[g*GRP_W +: GRP_W]),
                .co   (gc[g+1])
            );
        end
    end

    assign carry_out = gc[NGRP];
endmodule

// File: rtl/csa_inc_adder_chk.sv
module csa_inc_adder_chk #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned GRP_W  = 4
) (
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic              carry_in,
    input logic [DATA_W-1:0] sum_out,
    input logic              carry_out
);
    localparam int unsigned NGRP = DATA_W / GRP_W;

    logic [DATA_W:0] tot;
    assign tot = {1'b0, op_a} + {1'b0, op_b} + {{DATA_W{1'b0}}, carry_in};

    always_comb begin
        p_total_r1: assert ({carry_out, sum_out} == tot);
        p_base_r2: assert (sum_out[GRP_W-1:0] ==
            GRP_W'(op_a[GRP_W-1:0] + op_b[GRP_W-1:0] + {{(GRP_W-1){1'b0}}, carry_in}));
        if ((&op_a) && (&op_b) && carry_in)
            p_ones_r5: assert ((&sum_out) && carry_out);
        if (op_a == '0 && op_b == '0)
            p_zero_r6: assert (sum_out == DATA_W'(carry_in) && !carry_out);
    end

    for (genvar k = 1; k < NGRP; k++) begin : g_slice_chk
        localparam int unsigned LO = k * GRP_W;
        logic [LO:0]      low_t;
        logic [GRP_W:0]   slice_t;
        assign low_t   = {1'b0, op_a[LO-1:0]} + {1'b0, op_b[LO-1:0]} + {{LO{1'b0}}, carry_in};
        assign slice_t = {1'b0, op_a[LO +: GRP_W]} + {1'b0, op_b[LO +: GRP_W]}
                         + {{GRP_W{1'b0}}, low_t[LO]};
        always_comb begin
            p_slice_r3: assert (sum_out[LO +: GRP_W] == slice_t[GRP_W-1:0]);
        end
        if (k == NGRP - 1) begin : g_top
            always_comb begin
                p_topc_r4: assert (carry_out == slice_t[GRP_W]);
            end
        end
    end
endmodule

bind csa_inc_adder csa_inc_adder_chk #(.DATA_W(DATA_W), .GRP_W(GRP_W)) u_chk (
    .op_a     (op_a),
    .op_b     (op_b),
    .carry_in (carry_in),
    .sum_out  (sum_out),
    .carry_out(carry_out)
);

// File: tb/sim_csa_inc_adder.sv
`timescale 1ns/1ps
module sim_csa_inc_adder;
    logic        clk = 1'b0;
    logic [15:0] a, b;
    logic        ci;
    logic [15:0] s;
    logic        co;
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc   = 0;
    bit          done  = 0;

    always #4 clk = ~clk;

    csa_inc_adder u0 (
        .op_a(a), .op_b(b), .carry_in(ci), .sum_out(s), .carry_out(co)
    );

    task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s a=%h b=%h ci=%b actual=%h expected=%h", req, a, b, ci, act, exp);
        end
    endtask

    // drive at posedge, compare at negedge against a 17-bit integer model
    task automatic apply(input string req, input logic [15:0] va, input logic [15:0] vb, input logic vc);
        int unsigned ref_v;
        @(posedge clk);
        a = va; b = vb; ci = vc;
        @(negedge clk);
        ref_v = int'(va) + int'(vb) + int'(vc);
        check({req, " R1"}, {co, s}, 17'(ref_v));
        check("R2", {13'b0, s[3:0]}, 17'((int'(va[3:0]) + int'(vb[3:0]) + int'(vc)) % 16));
        for (int k = 1; k < 4; k++) begin
            int unsigned lo_mask, cin_k, sl;
            lo_mask = (1 << (4 * k)) - 1;
            cin_k = ((int'(va) & lo_mask) + (int'(vb) & lo_mask) + int'(vc)) >> (4 * k);
            sl = ((int'(va) >> (4 * k)) & 15) + ((int'(vb) >> (4 * k)) & 15) + cin_k;
            check("R3", {13'b0, s[4*k +: 4]}, 17'(sl % 16));
            if (k == 3) check("R4", {16'b0, co}, 17'(sl / 16));
        end
    endtask

    initial begin
        a = '0; b = '0; ci = 1'b0;
        // R6: zero operands
        apply("R6", 16'h0000, 16'h0000, 1'b0);
        check("R6", {co, s}, 17'h00000);
        apply("R6", 16'h0000, 16'h0000, 1'b1);
        check("R6", {co, s}, 17'h00001);
        // R5: all ones with carry in
        apply("R5", 16'hFFFF, 16'hFFFF, 1'b1);
        check("R5", {co, s}, 17'h1FFFF);
        // R7: carry across every boundary
        apply("R7", 16'hFFFF, 16'h0000, 1'b1);
        check("R7", {co, s}, 17'h10000);
        apply("R7", 16'h0FFF, 16'h0000, 1'b1);
        check("R7", {co, s}, 17'h01000);
        apply("R7", 16'h8421, 16'h7BDE, 1'b1);
        check("R7", {co, s}, 17'h10000);
        // R8: worked example in the low slice
        apply("R8", 16'h000B, 16'h000D, 1'b0);
        check("R8", {co, s}, 17'h00018);
        // R3/R4: slice sums of F with carry arriving from below
        for (int k = 1; k < 4; k++) begin
            logic [15:0] pa;
            pa = 16'hFFFF >> (4 * (3 - k));
            apply("R3", pa, 16'h0000, 1'b1);
            apply("R4", 16'h5A5A, 16'hA5A5, 1'b1);
            apply("R4", 16'hF00F, 16'h0FF1, 1'b0);
        end
        for (int i = 0; i < 2000; i++)
            apply("rand", 16'($urandom), 16'($urandom), 1'($urandom));
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule